// File: doc/BRIEF.md
# Register-Port Micro-Operation Sequencer

This block sits at the issue point of a small in-order core whose register file offers two read ports and a single write port. It takes one decoded instruction at a time over a valid/ready handshake and turns it into one or more micro-operations, offered one per cycle on a second valid/ready handshake. An instruction that needs more register traffic than one pass through the ports allows is cut into a fixed, class-specific sequence. Each micro-operation carries a kind code, a destination register, two source register numbers, a write enable and first/last markers.

The instruction classes cover:

- single-pass operations;
- loads that post-update their base;
- stores addressed by base plus register;
- double-word moves;
- divides;
- multiply-accumulates;
- multi-word loads and stores driven by a register bitmask.

For a bitmask transfer, an optional base write-back is placed after all word transfers. Decode, the register file, the execution units and memory all live elsewhere.

Top module: `regport_uop_seq`

## Requirements

Conventions used below:

- Class codes on `in_class`: 0 single, 1 post-update load, 2 register-offset store, 3 double move, 4 divide, 5 multiply-accumulate, 6 multi-load, 7 multi-store.
- Kind codes on `out_kind`: 0 pass, 1 load, 2 base update, 3 address, 4 store data, 5 move, 6 quotient, 7 remainder, 8 multiply, 9 accumulate, 10 word load, 11 word store, 12 empty.
- Unless a requirement says otherwise, a micro-operation has dst=`in_rt`, src A=`in_ra` and src B=`in_rb`.

- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Class 0 gives exactly one micro-op of kind 0, whose write enable equals `in_wb`.
- R3: Class 1 gives two micro-ops. The first is kind 1 with a write. The second is kind 2 with dst=`in_ra` and a write.
- R4: Class 2 gives two micro-ops, neither of which writes. The first is kind 3. The second is kind 4 with src A=`in_rt`.
- R5: Class 3 gives two kind-5 micro-ops, both writing. The first has dst and src A equal to `in_rt` and `in_ra` with bit 0 forced to 0. The second has bit 0 forced to 1.
- R6: Class 4 gives two writing micro-ops: kind 6 with dst=`in_rt`, then kind 7 with dst=`in_rs`.
- R7: Class 5 gives kind 8 without a write, then kind 9 with src A=`in_rt` and a write.
- R8: Class 6 gives one kind-10 micro-op per set bit of `in_mask`, in ascending register order. Each has dst and src B equal to that register number, and each writes.
- R9: Class 7 gives one kind-11 micro-op per set bit of `in_mask`, in ascending order. Each has dst and src B equal to that register number, and none writes.
- R10: For classes 6 and 7 with `in_wb`=1, one extra micro-op follows the word transfers: kind 2, dst=`in_ra`, with a write. If the mask is empty and `in_wb`=0, the block emits a single kind-12 micro-op that does not write.
- R11: `out_first` is 1 only on the first micro-op of an instruction, and `out_last` is 1 only on its final one. No micro-op is offered after the last one until a new instruction arrives.
- R12: `in_ready` is 0 while an instruction is in progress. In the cycle its last micro-op is accepted, `in_ready` is 1, so the next instruction is taken in that same cycle.
- R13: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction taken when high with in_valid |
| in_class | input | 3 | Instruction class code |
| in_rt | input | RW | Target register |
| in_ra | input | RW | First source / base register |
| in_rb | input | RW | Second source register |
| in_rs | input | RW | Secondary destination (remainder) |
| in_mask | input | NREG | Register list for multi-word transfers |
| in_wb | input | 1 | Result write (class 0) or base write-back (classes 6, 7) |
| out_valid | output | 1 | Micro-op offered |
| out_ready | input | 1 | Micro-op consumed when high with out_valid |
| out_kind | output | 4 | Micro-op kind code |
| out_dst | output | RW | Destination register |
| out_src_a | output | RW | Source register A |
| out_src_b | output | RW | Source register B |
| out_wen | output | 1 | Destination written |
| out_first | output | 1 | First micro-op of the instruction |
| out_last | output | 1 | Final micro-op of the instruction |

## Verification

The hardest situations to reach are the edges of the bitmask walk. The empty mask with and without write-back, a single set bit in the top position, and a full mask all land on different last-flag decisions. They also have to coincide with downstream stalls in the middle of a sequence. The bench uses an eight-register configuration and sweeps every mask value for both multi-word classes, with and without write-back. Throughout, it toggles `out_ready` from a pseudo-random sequence, so stalls land on first, middle and last micro-ops alike. A directed pair of back-to-back instructions then covers acceptance in the same cycle as the final micro-op.

// File: rtl/regport_uop_pkg.sv
package regport_uop_pkg;

    typedef enum logic [2:0] {
        C_SINGLE = 3'd0,
        C_LDPOST = 3'd1,
        C_STREG  = 3'd2,
        C_MOVD   = 3'd3,
        C_DIV    = 3'd4,
        C_MAC    = 3'd5,
        C_LMULTI = 3'd6,
        C_SMULTI = 3'd7
    } cls_e;

    typedef enum logic [3:0] {
        K_PASS   = 4'd0,
        K_LOAD   = 4'd1,
        K_BASE   = 4'd2,
        K_ADDR   = 4'd3,
        K_STDATA = 4'd4,
        K_MOVE   = 4'd5,
        K_QUOT   = 4'd6,
        K_REM    = 4'd7,
        K_MUL    = 4'd8,
        K_ACC    = 4'd9,
        K_LDW    = 4'd10,
        K_STW    = 4'd11,
        K_EMPTY  = 4'd12
    } kind_e;

    function automatic logic is_multi(input cls_e c);
        return (c == C_LMULTI) || (c == C_SMULTI);
    endfunction

endpackage

// File: rtl/regport_uop_lowbit.sv
module regport_uop_lowbit #(
    parameter int W  = 16,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any,
    output logic          more
);
    logic [W-1:0] below;
    logic [W-1:0] onehot;

    assign below[0]  = 1'b0;
    assign onehot[0] = vec[0];

    genvar gi;
    generate
        for (gi = 1; gi < W; gi++) begin : g_chain
            assign below[gi]  = below[gi-1] | vec[gi-1];
            assign onehot[gi] = vec[gi] & ~below[gi];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot[i]) idx = idx | IW'(i);
        end
    end

    assign any  = |vec;
    assign more = |(vec & ~onehot);
endmodule

// File: rtl/regport_uop_form.sv
module regport_uop_form
    import regport_uop_pkg::*;
#(
    parameter int NREG = 16,
    parameter int RW   = $clog2(NREG)
) (
    input  cls_e            cls,
    input  logic            phase,
    input  logic [RW-1:0]   rt,
    input  logic [RW-1:0]   ra,
    input  logic [RW-1:0]   rb,
    input  logic [RW-1:0]   rs,
    input  logic [NREG-1:0] mask,
    input  logic            wb,
    output kind_e           kind,
    output logic [RW-1:0]   dst,
    output logic [RW-1:0]   src_a,
    output logic [RW-1:0]   src_b,
    output logic            wen,
    output logic            last
);
    logic [RW-1:0] low_reg;
    logic          mask_any;
    logic          mask_more;

    regport_uop_lowbit #(.W(NREG), .IW(RW)) u_low (
        .vec  (mask),
        .idx  (low_reg),
        .any  (mask_any),
        .more (mask_more)
    );

    always_comb begin
        kind  = K_PASS;
        dst   = rt;
        src_a = ra;
        src_b = rb;
        wen   = 1'b0;
        last  = 1'b1;
        unique case (cls)
            C_SINGLE: begin
                wen = wb;
            end
            C_LDPOST: begin
                wen = 1'b1;
                if (!phase) begin
                    kind = K_LOAD;
                    last = 1'b0;
                end else begin
                    kind = K_BASE;
                    dst  = ra;
                end
            end
            C_STREG: begin
                if (!phase) begin
                    kind = K_ADDR;
                    last = 1'b0;
                end else begin
                    kind  = K_STDATA;
                    src_a = rt;
                end
            end
            C_MOVD: begin
                kind  = K_MOVE;
                wen   = 1'b1;
                dst   = {rt[RW-1:1], phase};
                src_a = {ra[RW-1:1], phase};
                last  = phase;
            end
            C_DIV: begin
                wen = 1'b1;
                if (!phase) begin
                    kind = K_QUOT;
                    last = 1'b0;
                end else begin
                    kind = K_REM;
                    dst  = rs;
                end
            end
            C_MAC: begin
                if (!phase) begin
                    kind = K_MUL;
                    last = 1'b0;
                end else begin
                    kind  = K_ACC;
                    src_a = rt;
                    wen   = 1'b1;
                end
            end
            C_LMULTI, C_SMULTI: begin
                if (mask_any) begin
                    kind  = (cls == C_LMULTI) ? K_LDW : K_STW;
                    wen   = (cls == C_LMULTI);
                    dst   = low_reg;
                    src_b = low_reg;
                    last  = !mask_more && !wb;
                end else if (wb) begin
                    kind = K_BASE;
                    dst  = ra;
                    wen  = 1'b1;
                end else begin
                    kind = K_EMPTY;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/regport_uop_seq.sv
module regport_uop_seq
    import regport_uop_pkg::*;
#(
    parameter int NREG = 16,
    parameter int RW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [2:0]      in_class,
    input  logic [RW-1:0]   in_rt,
    input  logic [RW-1:0]   in_ra,
    input  logic [RW-1:0]   in_rb,
    input  logic [RW-1:0]   in_rs,
    input  logic [NREG-1:0] in_mask,
    input  logic            in_wb,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [3:0]      out_kind,
    output logic [RW-1:0]   out_dst,
    output logic [RW-1:0]   out_src_a,
    output logic [RW-1:0]   out_src_b,
    output logic            out_wen,
    output logic            out_first,
    output logic            out_last
);
    localparam int CW = $clog2(NREG + 2) + 1;

    typedef struct packed {
        logic            busy;
        logic            first;
        logic            phase;
        cls_e            cls;
        logic [RW-1:0]   rt;
        logic [RW-1:0]   ra;
        logic [RW-1:0]   rb;
        logic [RW-1:0]   rs;
        logic [NREG-1:0] mask;
        logic            wb;
        logic [CW-1:0]   cnt;
    } seq_t;

    seq_t  st_d, st_q;
    kind_e kind;
    logic  take_in, take_out, last_w;

    regport_uop_form #(.NREG(NREG), .RW(RW)) u_form (
        .cls   (st_q.cls),
        .phase (st_q.phase),
        .rt    (st_q.rt),
        .ra    (st_q.ra),
        .rb    (st_q.rb),
        .rs    (st_q.rs),
        .mask  (st_q.mask),
        .wb    (st_q.wb),
        .kind  (kind),
        .dst   (out_dst),
        .src_a (out_src_a),
        .src_b (out_src_b),
        .wen   (out_wen),
        .last  (last_w)
    );

    assign out_valid = st_q.busy;
    assign out_kind  = kind;
    assign out_first = st_q.first;
    assign out_last  = last_w;
    assign take_out  = out_valid && out_ready;
    assign in_ready  = !st_q.busy || (take_out && last_w);
    assign take_in   = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (take_out) begin
            st_d.first = 1'b0;
            st_d.cnt   = st_q.cnt + CW'(1);
            if (last_w) begin
                st_d.busy = 1'b0;
            end else if (is_multi(st_q.cls)) begin
                st_d.mask = st_q.mask & (st_q.mask - NREG'(1));
            end else begin
                st_d.phase = 1'b1;
            end
        end
        if (take_in) begin
            st_d.busy  = 1'b1;
            st_d.first = 1'b1;
            st_d.phase = 1'b0;
            st_d.cls   = cls_e'(in_class);
            st_d.rt    = in_rt;
            st_d.ra    = in_ra;
            st_d.rb    = in_rb;
            st_d.rs    = in_rs;
            st_d.mask  = in_mask;
            st_d.wb    = in_wb;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_dst)
            && $stable(out_src_a) && $stable(out_src_b) && $stable(out_wen)
            && $stable(out_first) && $stable(out_last)));

    p_first_after_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_first));

    p_first_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> !out_first);

    p_busy_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && out_last)) |-> !in_ready);

    p_mop_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (st_q.cnt <= CW'(NREG)));

    p_base_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && is_multi(st_q.cls) && out_kind == 4'd2) |-> out_last);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready));
endmodule

// File: tb/regport_uop_seq_test.sv
module regport_uop_seq_test;
    localparam int TCLK = 10;
    localparam int NR   = 8;
    localparam int RW   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [2:0] in_class = '0;
    logic [RW-1:0] in_rt = '0, in_ra = '0, in_rb = '0, in_rs = '0;
    logic [NR-1:0] in_mask = '0;
    logic in_wb = 1'b0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [3:0] out_kind;
    logic [RW-1:0] out_dst, out_src_a, out_src_b;
    logic out_wen, out_first, out_last;

    int checks = 0;
    int errors = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [3:0]    ek [0:15];
    logic [RW-1:0] ed [0:15];
    logic [RW-1:0] ea [0:15];
    logic [RW-1:0] eb [0:15];
    logic          ew [0:15];
    int n_exp;

    always #(TCLK/2) clk = ~clk;

    regport_uop_seq #(.NREG(NR), .RW(RW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_class(in_class), .in_rt(in_rt), .in_ra(in_ra), .in_rb(in_rb),
        .in_rs(in_rs), .in_mask(in_mask), .in_wb(in_wb), .out_valid(out_valid),
        .out_ready(out_ready), .out_kind(out_kind), .out_dst(out_dst),
        .out_src_a(out_src_a), .out_src_b(out_src_b), .out_wen(out_wen),
        .out_first(out_first), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic [3:0] k, input logic [RW-1:0] d, input logic [RW-1:0] a,
                        input logic [RW-1:0] b, input logic w);
        ek[n_exp] = k; ed[n_exp] = d; ea[n_exp] = a; eb[n_exp] = b; ew[n_exp] = w;
        n_exp++;
    endtask

    task automatic build(input int c, input logic [RW-1:0] t, input logic [RW-1:0] a,
                         input logic [RW-1:0] b, input logic [RW-1:0] s,
                         input logic [NR-1:0] m, input logic w);
        n_exp = 0;
        case (c)
            0: push(4'd0, t, a, b, w);
            1: begin push(4'd1, t, a, b, 1'b1); push(4'd2, a, a, b, 1'b1); end
            2: begin push(4'd3, t, a, b, 1'b0); push(4'd4, t, t, b, 1'b0); end
            3: begin
                push(4'd5, {t[RW-1:1], 1'b0}, {a[RW-1:1], 1'b0}, b, 1'b1);
                push(4'd5, {t[RW-1:1], 1'b1}, {a[RW-1:1], 1'b1}, b, 1'b1);
            end
            4: begin push(4'd6, t, a, b, 1'b1); push(4'd7, s, a, b, 1'b1); end
            5: begin push(4'd8, t, a, b, 1'b0); push(4'd9, t, t, b, 1'b1); end
            default: begin
                for (int i = 0; i < NR; i++)
                    if (m[i]) push((c == 6) ? 4'd10 : 4'd11, RW'(i), a, RW'(i), (c == 6));
                if (w) push(4'd2, a, a, b, 1'b1);
                if (n_exp == 0) push(4'd12, t, a, b, 1'b0);
            end
        endcase
    endtask

    function automatic string tag_of(input int c, input logic [3:0] k);
        if (k == 4'd2 && c >= 6) return "R10";
        if (k == 4'd12) return "R10";
        case (c)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic run(input int c, input logic [RW-1:0] t, input logic [RW-1:0] a,
                       input logic [RW-1:0] b, input logic [RW-1:0] s,
                       input logic [NR-1:0] m, input logic w);
        int idx, guard;
        bit held;
        logic [RW*3+7:0] saved;
        build(c, t, a, b, s, m, w);
        @(negedge clk);
        in_class = 3'(c); in_rt = t; in_ra = a; in_rb = b; in_rs = s; in_mask = m; in_wb = w;
        in_valid = 1'b1;
        #1 check(in_ready === 1'b1, "R12", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        idx = 0; guard = 0; held = 0; saved = '0;
        while (idx < n_exp && guard < 400) begin
            out_ready = lfsr[0] | lfsr[5];
            #1;
            if (held)
                check(out_valid && saved == {out_kind, out_dst, out_src_a, out_src_b, out_wen, out_first, out_last},
                      "R13", {out_kind, out_dst, out_src_a, out_src_b, out_wen, out_first, out_last}, saved);
            held = out_valid && !out_ready;
            saved = {out_kind, out_dst, out_src_a, out_src_b, out_wen, out_first, out_last};
            if (out_valid && out_ready) begin
                check({out_kind, out_dst, out_src_a, out_src_b, out_wen} ==
                      {ek[idx], ed[idx], ea[idx], eb[idx], ew[idx]}, tag_of(c, ek[idx]),
                      {out_kind, out_dst, out_src_a, out_src_b, out_wen},
                      {ek[idx], ed[idx], ea[idx], eb[idx], ew[idx]});
                check({out_first, out_last} == {idx == 0, idx == n_exp - 1}, "R11",
                      {out_first, out_last}, {idx == 0, idx == n_exp - 1});
                check(in_ready == (idx == n_exp - 1), "R12", {31'd0, in_ready}, idx == n_exp - 1);
                idx++;
            end
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            guard++;
        end
        check(guard < 400, "R11", guard, 400);
        #1 check(out_valid === 1'b0, "R11", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 check(out_valid === 1'b0 && in_ready === 1'b1, "R1", {out_valid, in_ready}, 2'b01);
        rst_n = 1'b1;
        // two-micro-op and single classes over register patterns (R2..R7)
        for (int c = 0; c < 6; c++)
            for (int r = 0; r < NR; r++)
                for (int w = 0; w < 2; w++)
                    run(c, RW'(r), RW'(r * 3 + 1), RW'(r * 5 + 2), RW'(7 - r), '0, w[0]);
        // every mask, both multi-word classes, with and without base write-back (R8, R9, R10)
        for (int c = 6; c < 8; c++)
            for (int m = 0; m < (1 << NR); m++)
                for (int w = 0; w < 2; w++)
                    run(c, RW'(m), RW'(m >> 3), RW'(m + 5), RW'(1), NR'(m), w[0]);
        // back-to-back: next instruction taken with the last micro-op (R12)
        @(negedge clk);
        out_ready = 1'b1;
        in_class = 3'd0; in_rt = 3'd1; in_ra = 3'd2; in_rb = 3'd3; in_wb = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        in_rt = 3'd6;
        #1 check(out_valid && out_dst == 3'd1 && in_ready, "R12", {out_valid, out_dst, in_ready}, {1'b1, 3'd1, 1'b1});
        @(negedge clk);
        in_valid = 1'b0;
        #1 check(out_valid && out_dst == 3'd6 && out_first && out_last && out_kind == 4'd0, "R2",
                 {out_valid, out_dst, out_first, out_last}, {1'b1, 3'd6, 2'b11});
        @(negedge clk);
        #1 check(out_valid === 1'b0, "R11", {31'd0, out_valid}, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule